// File: doc/BRIEF.md
# Address-Decoding Bus Fabric

This block sits between one master and several slaves on a register bus that uses a strobe and an acknowledge. The master presents an address, write data, a write flag and a strobe. Each slave answers with read data, an acknowledge and an error flag. The fabric compares the master address with a parameter table. Each table entry gives a slave's base address and how many of its low address bits the slave decodes itself.

Address, write data and the write flag go unchanged to every slave. Selection is made only by gating the strobe, so only the selected slave sees a transaction. The selected slave's read data, acknowledge and error are routed back to the master. If the master strobes an address that no table entry covers, the fabric answers by itself with a one-cycle error and gives no acknowledge. All routing is combinational. The only register is the one that produces the error for an unmatched address.

The default table has three slaves:
- a pair of registers at base 0x0 with 1 local bit,
- a single register at 0x2 with 0 local bits,
- a 16-word window at 0x1000 with 4 local bits.

Top module: `fab_bus_fabric`

## Requirements
- R1: `s_stb[i]` is high exactly when `m_stb` is high and slave i is the selected slave. All other slave strobes are low.
- R2: `m_addr`, `m_wdata` and `m_we` appear unchanged on `s_addr[i]`, `s_wdata[i]` and `s_we[i]` for every slave i, whatever the selection.
- R3: Slave i matches an address when the address bits at and above position `SLV_BITS[i]` equal the same bits of `SLV_BASE[i]`. With the default table, addresses 0x0–0x1 select slave 0, 0x2 selects slave 1, 0x1000–0x100F select slave 2, and every other 32-bit address matches nothing.
- R4: When several entries match one address, the entry with the lowest index is selected.
- R5: At most one slave strobe is high in any cycle.
- R6: `m_rdata` equals `s_rdata` of the selected slave. It is zero when no slave matches the address.
- R7: `m_ack` and `m_err` follow only the selected slave's `s_ack` and `s_err`. The acknowledge and error inputs of unselected slaves have no effect.
- R8: When `m_stb` is high on an unmatched address at a rising clock edge, and the fabric did not raise its own error in the previous cycle, `m_err` is high for exactly the following cycle. During that cycle `m_ack` stays low. If the strobe is held, the error repeats no more often than every second cycle. A strobe on a matched address never raises the fabric's own error.
- R9: `rst_n` is a synchronous active-low reset. While it is low, the fabric raises no error of its own. Strobe gating and response routing still work during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| m_addr | input | AW | Master address |
| m_wdata | input | DW | Master write data |
| m_we | input | 1 | Master write flag |
| m_stb | input | 1 | Master strobe |
| m_rdata | output | DW | Read data to the master |
| m_ack | output | 1 | Acknowledge to the master |
| m_err | output | 1 | Error to the master |
| s_addr | output | N_SLV×AW | Address copy for each slave |
| s_wdata | output | N_SLV×DW | Write data copy for each slave |
| s_we | output | N_SLV | Write flag copy for each slave |
| s_stb | output | N_SLV | Gated strobe for each slave |
| s_rdata | input | N_SLV×DW | Read data from each slave |
| s_ack | input | N_SLV | Acknowledge from each slave |
| s_err | input | N_SLV | Error from each slave |

## Verification
Two functions can act in the same cycle. The fabric's own miss error can coincide with slave responses, so the master error must not mix them. Also, the combinational decode that gates the strobes keeps running while the miss-error register is held in reset.

The first case is provoked by holding every slave's acknowledge and error high while sweeping unmatched addresses. The check is that `m_ack` stays low and `m_err` comes only from the registered pulse, one cycle late.

The second case is provoked by sweeping thousands of addresses with the strobe high during reset. The check is that every gated strobe matches an arithmetic range test in the bench while `m_err` stays low.

A second instance with overlapping windows checks the lowest-index priority.

// File: rtl/fab_pkg.sv
// Package fab_pkg
// Shared constants and types for the address-decoding bus fabric.
// Assumes nothing beyond standard SystemVerilog.
package fab_pkg;
    // Width of each entry in the per-slave local-bit-count table
    localparam int FAB_BITS_W = 8;

    // State of the fabric's own error responder
    typedef enum logic {
        MISS_IDLE = 1'b0,
        MISS_ERR  = 1'b1
    } fab_miss_st_e;
endpackage

// File: rtl/fab_decode.sv
// Module fab_decode
// Compares one address against every table entry.
// Each entry i covers the addresses whose bits at and above SLV_BITS[i]
// equal those of SLV_BASE[i].
// Returns a one-hot selection, in which the lowest matching index wins,
// and a flag that is set when nothing matches.
// Assumes SLV_BITS[i] <= AW. It is purely combinational.
module fab_decode #(
    parameter int N_SLV = 3,
    parameter int AW    = 32,
    parameter int BW    = fab_pkg::FAB_BITS_W,
    parameter logic [N_SLV-1:0][AW-1:0] SLV_BASE = '0,
    parameter logic [N_SLV-1:0][BW-1:0] SLV_BITS = '0
) (
    input  logic [AW-1:0]    addr,
    output logic [N_SLV-1:0] sel,
    output logic             miss
);
    logic [N_SLV-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < N_SLV; gi++) begin : g_entry
            localparam logic [AW-1:0] HI_MASK = {AW{1'b1}} << SLV_BITS[gi];
            // Raw match of entry gi: upper bits equal the base address
            assign hit[gi] = (((addr ^ SLV_BASE[gi]) & HI_MASK) == '0);
        end
    endgenerate

    // Priority pick: keep only the lowest-index hit
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < N_SLV; i++) begin
            sel[i] = hit[i] & ~seen;
            seen   = seen | hit[i];
        end
        miss = ~seen;
    end
endmodule

// File: rtl/fab_miss_err.sv
// Module fab_miss_err
// Answers a strobe on an unmatched address with an error one cycle long.
// The error goes high in the cycle after the edge that sees the strobe.
// A held strobe cannot produce two error cycles in a row.
// Reset is synchronous and active low.
module fab_miss_err (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic miss,
    output logic err
);
    import fab_pkg::*;

    fab_miss_st_e st_q;

    // Single-cycle error pulse state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= MISS_IDLE;
        end else if (st_q == MISS_ERR) begin
            st_q <= MISS_IDLE;
        end else if (stb && miss) begin
            st_q <= MISS_ERR;
        end
    end

    assign err = (st_q == MISS_ERR);

    // R8
    err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(stb && miss));
endmodule

// File: rtl/fab_resp_mux.sv
// Module fab_resp_mux
// Returns the response of the selected slave to the master.
// Read data is built as an AND-OR of the slave read data, so it is zero
// when no slave is selected.
// Acknowledge and error are the OR of the selected slave's flags.
// The fabric's own miss error is added to the error.
// Assumes sel is one-hot or zero. It is purely combinational.
module fab_resp_mux #(
    parameter int N_SLV = 3,
    parameter int DW    = 32
) (
    input  logic [N_SLV-1:0]         sel,
    input  logic [N_SLV-1:0][DW-1:0] s_rdata,
    input  logic [N_SLV-1:0]         s_ack,
    input  logic [N_SLV-1:0]         s_err,
    input  logic                     miss_err,
    output logic [DW-1:0]            m_rdata,
    output logic                     m_ack,
    output logic                     m_err
);
    // AND-OR combine of the selected slave's response
    always_comb begin
        m_rdata = '0;
        m_ack   = 1'b0;
        m_err   = miss_err;
        for (int i = 0; i < N_SLV; i++) begin
            m_rdata = m_rdata | (s_rdata[i] & {DW{sel[i]}});
            m_ack   = m_ack | (s_ack[i] & sel[i]);
            m_err   = m_err | (s_err[i] & sel[i]);
        end
    end
endmodule

// File: rtl/fab_bus_fabric.sv
// Module fab_bus_fabric
// Top of the address-decoding bus fabric.
// It connects one master port to N_SLV slave ports. The write-side signals
// go to every slave, and the strobe reaches only the slave that the
// decode table selects.
// The response of that slave returns to the master. A strobe on an
// unmatched address gets a one-cycle error generated by the fabric.
// Assumes the master holds its request stable until ack or err.
// Reset is synchronous and active low.
module fab_bus_fabric #(
    parameter int N_SLV = 3,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BW    = fab_pkg::FAB_BITS_W,
    parameter logic [N_SLV-1:0][AW-1:0] SLV_BASE = {32'h0000_1000, 32'h0000_0002, 32'h0000_0000},
    parameter logic [N_SLV-1:0][BW-1:0] SLV_BITS = {8'd4, 8'd0, 8'd1}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            m_addr,
    input  logic [DW-1:0]            m_wdata,
    input  logic                     m_we,
    input  logic                     m_stb,
    output logic [DW-1:0]            m_rdata,
    output logic                     m_ack,
    output logic                     m_err,
    output logic [N_SLV-1:0][AW-1:0] s_addr,
    output logic [N_SLV-1:0][DW-1:0] s_wdata,
    output logic [N_SLV-1:0]         s_we,
    output logic [N_SLV-1:0]         s_stb,
    input  logic [N_SLV-1:0][DW-1:0] s_rdata,
    input  logic [N_SLV-1:0]         s_ack,
    input  logic [N_SLV-1:0]         s_err
);
    logic [N_SLV-1:0] sel;
    logic             miss;
    logic             miss_err;

    fab_decode #(
        .N_SLV    (N_SLV),
        .AW       (AW),
        .BW       (BW),
        .SLV_BASE (SLV_BASE),
        .SLV_BITS (SLV_BITS)
    ) u_decode (
        .addr (m_addr),
        .sel  (sel),
        .miss (miss)
    );

    fab_miss_err u_miss_err (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (m_stb),
        .miss  (miss),
        .err   (miss_err)
    );

    genvar gi;
    generate
        for (gi = 0; gi < N_SLV; gi++) begin : g_port
            // Broadcast of the write-side bus and gated strobe for slave gi
            assign s_addr[gi]  = m_addr;
            assign s_wdata[gi] = m_wdata;
            assign s_we[gi]    = m_we;
            assign s_stb[gi]   = m_stb & sel[gi];
        end
    endgenerate

    fab_resp_mux #(
        .N_SLV (N_SLV),
        .DW    (DW)
    ) u_resp (
        .sel      (sel),
        .s_rdata  (s_rdata),
        .s_ack    (s_ack),
        .s_err    (s_err),
        .miss_err (miss_err),
        .m_rdata  (m_rdata),
        .m_ack    (m_ack),
        .m_err    (m_err)
    );

    // R5
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_stb));

    // R1
    stb_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_stb) |-> m_stb);

    // R8
    miss_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_stb && miss) |-> (!m_ack && s_stb == '0));

    // R6
    miss_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (m_rdata == '0));
endmodule

// File: tb/test_fab_bus_fabric.sv
module test_fab_bus_fabric;
    localparam int N  = 3;
    localparam int AW = 32;
    localparam int DW = 32;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // main instance
    logic [AW-1:0]        m_addr  = '0;
    logic [DW-1:0]        m_wdata = '0;
    logic                 m_we    = 1'b0;
    logic                 m_stb   = 1'b0;
    logic [DW-1:0]        m_rdata;
    logic                 m_ack, m_err;
    logic [N-1:0][AW-1:0] s_addr;
    logic [N-1:0][DW-1:0] s_wdata;
    logic [N-1:0]         s_we, s_stb;
    logic [N-1:0][DW-1:0] s_rdata;
    logic [N-1:0]         s_ack = '0;
    logic [N-1:0]         s_err = '0;

    assign s_rdata[0] = 32'hC0DE_0A00;
    assign s_rdata[1] = 32'hC0DE_0B11;
    assign s_rdata[2] = 32'hC0DE_0C22;

    fab_bus_fabric i_fab_bus_fabric (
        .clk(clk), .rst_n(rst_n),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_we(m_we), .m_stb(m_stb),
        .m_rdata(m_rdata), .m_ack(m_ack), .m_err(m_err),
        .s_addr(s_addr), .s_wdata(s_wdata), .s_we(s_we), .s_stb(s_stb),
        .s_rdata(s_rdata), .s_ack(s_ack), .s_err(s_err)
    );

    // overlapping table: slave0 = 0x18..0x1F, slave1 = 0x10..0x1F
    logic [AW-1:0]        o_addr = '0;
    logic                 o_stb  = 1'b0;
    logic [DW-1:0]        o_rdata;
    logic                 o_ack, o_err;
    logic [1:0][AW-1:0]   o_saddr;
    logic [1:0][DW-1:0]   o_swdata;
    logic [1:0]           o_swe, o_sstb;
    logic [1:0][DW-1:0]   o_srdata;

    assign o_srdata[0] = 32'h0000_AAAA;
    assign o_srdata[1] = 32'h0000_BBBB;

    fab_bus_fabric #(
        .N_SLV(2), .AW(AW), .DW(DW),
        .SLV_BASE({32'h0000_0010, 32'h0000_0018}),
        .SLV_BITS({8'd4, 8'd3})
    ) i_fab_bus_fabric_ovl (
        .clk(clk), .rst_n(rst_n),
        .m_addr(o_addr), .m_wdata(32'h0), .m_we(1'b0), .m_stb(o_stb),
        .m_rdata(o_rdata), .m_ack(o_ack), .m_err(o_err),
        .s_addr(o_saddr), .s_wdata(o_swdata), .s_we(o_swe), .s_stb(o_sstb),
        .s_rdata(o_srdata), .s_ack(2'b11), .s_err(2'b00)
    );

    function automatic int exp_sel(input logic [31:0] a);
        if (a < 32'd2) return 0;
        if (a == 32'd2) return 1;
        if (a >= 32'h1000 && a < 32'h1010) return 2;
        return -1;
    endfunction

    function automatic int exp_sel_ovl(input logic [31:0] a);
        if (a >= 32'h18 && a < 32'h20) return 0;
        if (a >= 32'h10 && a < 32'h18) return 1;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] extra_addr(input int k);
        case (k)
            0: return 32'h0001_1000;
            1: return 32'h8000_0002;
            2: return 32'h8000_0000;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic sweep_one(input logic [31:0] a, input bit in_reset);
        int e;
        logic [31:0] er;
        logic [N-1:0] es;
        m_addr = a;
        #1;
        e  = exp_sel(a);
        er = (e < 0) ? 32'h0 : s_rdata[e];
        es = (e < 0) ? '0 : (N'(1) << e);
        if (!in_reset) begin
            // R3 R6 selection seen through read data
            check(m_rdata == er, "R6", m_rdata, er);
            // R7 all slaves ack, only selected one reaches master
            check(m_ack == (e >= 0), "R7", {31'h0, m_ack}, {31'h0, e >= 0});
            check(s_stb == '0, "R1", {29'h0, s_stb}, 32'h0);
        end else begin
            // R3 R1 strobe gating while in reset
            check(s_stb == es, "R3", {29'h0, s_stb}, {29'h0, es});
            // R9 no fabric error during reset
            check(m_err == 1'b0, "R9", {31'h0, m_err}, 32'h0);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // reset state (R9)
        @(negedge clk);
        @(negedge clk);
        check(m_err == 1'b0 && m_ack == 1'b0, "R9", {30'h0, m_err, m_ack}, 32'h0);

        // strobe sweep held in reset (R3, R1, R9)
        m_stb = 1'b1;
        for (int a = 0; a < 32'h1100; a++) sweep_one(32'(a), 1'b1);
        for (int k = 0; k < 4; k++) sweep_one(extra_addr(k), 1'b1);
        m_stb = 1'b0;

        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // no-strobe sweep with every slave acking (R6, R7)
        s_ack = '1;
        s_err = '0;
        for (int a = 0; a < 32'h1100; a++) sweep_one(32'(a), 1'b0);
        for (int k = 0; k < 4; k++) sweep_one(extra_addr(k), 1'b0);

        // broadcast (R2)
        m_addr = 32'h1234_5678; m_wdata = 32'hA5A5_5A5A; m_we = 1'b1;
        #1;
        for (int i = 0; i < N; i++) begin
            check(s_addr[i] == m_addr, "R2", s_addr[i], m_addr);
            check(s_wdata[i] == m_wdata, "R2", s_wdata[i], m_wdata);
            check(s_we[i] == 1'b1, "R2", {31'h0, s_we[i]}, 32'h1);
        end
        m_we = 1'b0;

        // unselected responses ignored (R7)
        @(negedge clk);
        m_addr = 32'h0; m_stb = 1'b1; s_ack = 3'b110; s_err = 3'b110;
        #1;
        check(m_ack == 1'b0 && m_err == 1'b0, "R7", {30'h0, m_ack, m_err}, 32'h0);
        check(s_stb == 3'b001, "R1", {29'h0, s_stb}, 32'h1);
        s_ack = 3'b001; s_err = 3'b000;
        #1;
        check(m_ack == 1'b1, "R7", {31'h0, m_ack}, 32'h1);
        s_ack = 3'b000; s_err = 3'b100; m_addr = 32'h1005;
        #1;
        check(m_err == 1'b1 && m_ack == 1'b0, "R7", {30'h0, m_err, m_ack}, 32'h2);
        // matched strobe across an edge: no fabric error (R8)
        @(posedge clk); #1;
        s_err = '0;
        #0.5;
        check(m_err == 1'b0, "R8", {31'h0, m_err}, 32'h0);

        // miss error timing with slaves all responding (R8)
        @(negedge clk);
        s_ack = '1; s_err = '1;
        m_addr = 32'h0000_0500; m_stb = 1'b1;
        #1;
        check(m_err == 1'b0 && m_ack == 1'b0, "R8", {30'h0, m_err, m_ack}, 32'h0);
        @(posedge clk); #1;
        check(m_err == 1'b1 && m_ack == 1'b0, "R8", {30'h0, m_err, m_ack}, 32'h2);
        // held strobe: error drops next cycle, then returns
        @(posedge clk); #1;
        check(m_err == 1'b0, "R8", {31'h0, m_err}, 32'h0);
        @(posedge clk); #1;
        check(m_err == 1'b1, "R8", {31'h0, m_err}, 32'h1);
        @(negedge clk);
        m_stb = 1'b0;
        @(posedge clk); #1;
        check(m_err == 1'b0, "R8", {31'h0, m_err}, 32'h0);

        // miss strobe in reset does not raise fabric error (R9)
        @(negedge clk);
        rst_n = 1'b0; m_stb = 1'b1;
        @(posedge clk); #1;
        check(m_err == 1'b0, "R9", {31'h0, m_err}, 32'h0);
        @(posedge clk); #1;
        check(m_err == 1'b0, "R9", {31'h0, m_err}, 32'h0);
        @(negedge clk);
        m_stb = 1'b0; rst_n = 1'b1;

        // priority on overlapping table (R4)
        for (int a = 0; a < 64; a++) begin
            int e;
            logic [31:0] er;
            o_addr = 32'(a); o_stb = 1'b1;
            #1;
            e  = exp_sel_ovl(32'(a));
            er = (e < 0) ? 32'h0 : o_srdata[e];
            check(o_rdata == er, "R4", o_rdata, er);
            check(o_sstb == ((e < 0) ? 2'b00 : (2'b01 << e)), "R4", {30'h0, o_sstb},
                  (e < 0) ? 32'h0 : (32'h1 << e));
        end
        o_stb = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule